// File: doc/BRIEF.md
# Interrupt Acknowledge CPU Interface

This block is the per-processor end of an interrupt controller. An upstream pending and priority stage presents one candidate at a time as an ID, an 8-bit priority and a valid flag. The block checks the candidate against a programmable priority threshold, the group enable and the priority of the interrupts already being serviced. It drives the processor's request line when the candidate qualifies.

Software uses a small register port. A read of the acknowledge register takes the candidate, pushes its priority and ID onto a running-priority stack of up to four entries, and pulses an activation strobe upstream. A write to the end-of-interrupt register retires the most recent active interrupt. Depending on the completion mode, the same write either also deactivates the interrupt upstream, or leaves that to a separate deactivate register.

Register offsets on `reg_addr`: 0 control, 1 group enable, 2 priority mask, 3 acknowledge (read), 4 end of interrupt (write), 5 running priority (read), 6 deactivate (write). Lower priority values are more urgent: 0x00 is the most urgent and 0xFF the least.

Top module: `irq_ack_cpuif`

## Requirements
- R1: After reset, `irq` is low and the registers read back as control 0, group enable 0, priority mask 0x00 and running priority 0xFF (the idle value when no interrupt is active).
- R2: The priority mask (offset 2) keeps only write bits 7:0. The control register (offset 0) keeps only bit 1, the completion-mode bit. The group enable (offset 1) keeps only bit 0.
- R3: `irq` is high exactly when all of the following hold: the candidate is valid, group-enable bit 0 is set, the candidate priority is numerically below the mask, the candidate priority is numerically below the running priority, the ID is valid and the stack is not full.
- R4: An acknowledge read (offset 3) while `irq` is high returns the candidate ID. In that same cycle it pulses `act_valid` with `act_id` equal to the ID. From the next cycle the running priority equals the candidate's priority, and `irq` is low for that same candidate.
- R5: An acknowledge read while nothing qualifies returns the reserved ID 1023, leaves `act_valid` low and changes no state.
- R6: A new candidate preempts only if its priority is strictly lower in value than the running priority. An equal priority does not raise `irq`.
- R7: An end-of-interrupt write (offset 4) whose data equals the ID on top of the stack pops the stack. The running priority returns to the entry below, or to 0xFF if the stack is then empty.
- R8: An end-of-interrupt write whose data is not the top ID, or one made while the stack is empty, has no effect.
- R9: With control bit 1 clear, a matching end-of-interrupt write also pulses `deact_valid` with the ID in that cycle, and deactivate writes (offset 6) are ignored. With bit 1 set, end of interrupt only drops the priority, and a deactivate write pulses `deact_valid` with `deact_id` equal to its data.
- R10: With four interrupts active, no candidate raises `irq`, whatever its priority. An acknowledge read then returns 1023.
- R11: IDs 1020 through 8191 are reserved and never raise `irq`. IDs 0 to 1019 and 8192 and above can be signalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cand_valid | input | 1 | Upstream candidate present |
| cand_id | input | ID_W | Candidate interrupt ID |
| cand_prio | input | PRIO_W | Candidate priority, lower is more urgent |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational in the read cycle |
| irq | output | 1 | Interrupt request to the processor |
| act_valid | output | 1 | Acknowledge taken, mark ID active upstream |
| act_id | output | ID_W | ID being activated |
| deact_valid | output | 1 | Deactivate ID upstream |
| deact_id | output | ID_W | ID being deactivated |

## Verification
A corrupted stack pointer or stack entry shows up at the ports. The running-priority read gives the wrong value, and preemption lets a candidate through or blocks it against the wrong level, one cycle after the acknowledge or end of interrupt that caused it. A wrong top ID turns a valid end of interrupt into a silent no-op, which the bench sees on the same cycle through `deact_valid` and on the next cycle through the running priority. Qualification faults show at once on `irq` and on the acknowledge value, since both derive combinationally from registered state.

// File: rtl/irq_ack_cpuif.sv
module irq_ack_cpuif #(
  parameter int ID_W   = 14,
  parameter int PRIO_W = 8,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cand_valid,
  input  logic [ID_W-1:0]   cand_id,
  input  logic [PRIO_W-1:0] cand_prio,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq,
  output logic              act_valid,
  output logic [ID_W-1:0]   act_id,
  output logic              deact_valid,
  output logic [ID_W-1:0]   deact_id
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [ID_W-1:0] SPUR_ID = ID_W'(1023);
  localparam logic [ID_W-1:0] RSV_LO  = ID_W'(1020);
  localparam logic [ID_W-1:0] RSV_HI  = ID_W'(8192);
  localparam logic [2:0] A_CTL = 3'd0, A_GRP = 3'd1, A_PMR = 3'd2, A_ACK = 3'd3,
                         A_EOI = 3'd4, A_RUN = 3'd5, A_DIR = 3'd6;

  logic              eoi_mode, grp_en;
  logic [PRIO_W-1:0] pmr;
  logic [CW-1:0]     cnt;
  logic [ID_W-1:0]   s_id [DEPTH];
  logic [PRIO_W-1:0] s_pr [DEPTH];

  logic [IW-1:0]     top_idx;
  logic [ID_W-1:0]   top_id;
  logic [PRIO_W-1:0] run_prio;
  logic              id_ok, qual, rd_ack, push, eoi_hit, pop;

  assign top_idx  = IW'(cnt - CW'(1));
  assign top_id   = (cnt == '0) ? '0 : s_id[top_idx];
  assign run_prio = (cnt == '0) ? '1 : s_pr[top_idx];

  assign id_ok = (cand_id < RSV_LO) || (cand_id >= RSV_HI);
  assign qual  = cand_valid && grp_en && id_ok && (cand_prio < pmr)
              && (cand_prio < run_prio) && (cnt != CW'(DEPTH));
  assign irq   = qual;

  assign rd_ack  = reg_rd && (reg_addr == A_ACK);
  assign push    = rd_ack && qual;
  assign eoi_hit = reg_wr && (reg_addr == A_EOI) && (cnt != '0)
                && (reg_wdata == 32'(top_id));
  assign pop     = eoi_hit;

  assign act_valid   = push;
  assign act_id      = cand_id;
  assign deact_valid = (eoi_hit && !eoi_mode) || (reg_wr && reg_addr == A_DIR && eoi_mode);
  assign deact_id    = reg_wdata[ID_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eoi_mode <= 1'b0;
      grp_en   <= 1'b0;
      pmr      <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        A_CTL:   eoi_mode <= reg_wdata[1];
        A_GRP:   grp_en   <= reg_wdata[0];
        A_PMR:   pmr      <= reg_wdata[PRIO_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (push) cnt <= cnt + CW'(1);
    else if (pop)  cnt <= cnt - CW'(1);
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_stk
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        s_id[g] <= '0;
        s_pr[g] <= '0;
      end else if (push && cnt == CW'(g)) begin
        s_id[g] <= cand_id;
        s_pr[g] <= cand_prio;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTL:   reg_rdata[1] = eoi_mode;
      A_GRP:   reg_rdata[0] = grp_en;
      A_PMR:   reg_rdata[PRIO_W-1:0] = pmr;
      A_ACK:   reg_rdata[ID_W-1:0] = qual ? cand_id : SPUR_ID;
      A_RUN:   reg_rdata[PRIO_W-1:0] = run_prio;
      default: ;
    endcase
  end
endmodule

// File: rtl/irq_ack_cpuif_chk.sv
module irq_ack_cpuif_chk #(
  parameter int PRIO_W = 8,
  parameter int DEPTH  = 4,
  parameter int CW     = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              irq,
  input logic              grp_en,
  input logic [PRIO_W-1:0] pmr,
  input logic [PRIO_W-1:0] cand_prio,
  input logic [PRIO_W-1:0] run_prio,
  input logic [CW-1:0]     cnt,
  input logic              push,
  input logic              eoi_hit
);
  // R3
  grp_gate_chk: assert property (@(posedge clk) disable iff (!rst_n) !grp_en |-> !irq);
  // R3
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) irq |-> (cand_prio < pmr));
  // R6
  preempt_chk: assert property (@(posedge clk) disable iff (!rst_n) irq |-> (cand_prio < run_prio));
  // R10
  full_block_chk: assert property (@(posedge clk) disable iff (!rst_n) (cnt >= CW'(DEPTH)) |-> !irq);
  // R4
  ack_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> (run_prio == $past(cand_prio)) && (cnt == $past(cnt) + CW'(1)));
  // R7
  eoi_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_hit |=> (cnt == $past(cnt) - CW'(1)));
endmodule

bind irq_ack_cpuif irq_ack_cpuif_chk #(.PRIO_W(PRIO_W), .DEPTH(DEPTH), .CW(CW)) i_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .grp_en(grp_en), .pmr(pmr),
  .cand_prio(cand_prio), .run_prio(run_prio), .cnt(cnt), .push(push), .eoi_hit(eoi_hit)
);

// File: tb/test_irq_ack_cpuif.sv
module test_irq_ack_cpuif;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cand_valid = 1'b0;
  logic [13:0] cand_id = '0;
  logic [7:0]  cand_prio = '0;
  logic        reg_rd = 1'b0, reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq, act_valid, deact_valid;
  logic [13:0] act_id, deact_id;

  int total = 0, bad = 0;
  bit done = 1'b0;
  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #5 clk = ~clk;

  irq_ack_cpuif i_irq_ack_cpuif (
    .clk(clk), .rst_n(rst_n), .cand_valid(cand_valid), .cand_id(cand_id),
    .cand_prio(cand_prio), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .act_valid(act_valid),
    .act_id(act_id), .deact_valid(deact_valid), .deact_id(deact_id)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data and compares it to the port
  always begin
    @(negedge clk);
    #3;
    if (reg_rd && exp_q.size() > 0) chk(reg_rdata, exp_q.pop_front(), tag_q.pop_front());
  end

  task automatic rd(input logic [2:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(posedge clk); #1 reg_rd = 1'b0;
  endtask

  task automatic ack(input logic [31:0] e, input logic ea, input string tag);
    @(negedge clk);
    reg_addr = 3'd3; reg_rd = 1'b1;
    exp_q.push_back(e); tag_q.push_back(tag);
    #3;
    chk(32'(act_valid), 32'(ea), tag);
    if (ea) chk(32'(act_id), e, tag);
    @(posedge clk); #1 reg_rd = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d, input logic ed, input string tag);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    #3;
    chk(32'(deact_valid), 32'(ed), tag);
    if (ed) chk(32'(deact_id), d, tag);
    @(posedge clk); #1 reg_wr = 1'b0;
  endtask

  task automatic cand(input logic v, input logic [13:0] id, input logic [7:0] p);
    @(negedge clk);
    cand_valid = v; cand_id = id; cand_prio = p;
  endtask

  task automatic irqc(input logic e, input string tag);
    @(negedge clk);
    #3 chk(32'(irq), 32'(e), tag);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #3 chk(32'(irq), 0, "R1 irq in reset");
    rst_n = 1'b1;
    rd(3'd0, 0, "R1 ctl");
    rd(3'd1, 0, "R1 grp");
    rd(3'd2, 0, "R1 pmr");
    rd(3'd5, 32'hFF, "R1 running");

    wr(3'd2, 32'h1F0, 0, "R2 pmr wr");
    rd(3'd2, 32'hF0, "R2 pmr low byte");
    wr(3'd0, 32'hFFFF_FFFF, 0, "R2 ctl wr");
    rd(3'd0, 32'h2, "R2 ctl bit1 only");
    wr(3'd0, 0, 0, "R2 ctl clr");
    wr(3'd1, 32'hFFFF_FFFE, 0, "R2 grp wr");
    rd(3'd1, 0, "R2 grp bit0 only");

    cand(1, 14'd40, 8'h80);
    irqc(0, "R3 group disabled");
    ack(32'd1023, 0, "R5 spurious ack");
    rd(3'd5, 32'hFF, "R5 no state change");
    wr(3'd1, 1, 0, "R3 grp on");
    irqc(1, "R3 qualifies");
    wr(3'd2, 32'h80, 0, "R3 pmr equal");
    irqc(0, "R3 prio not below mask");
    wr(3'd2, 32'hF0, 0, "R3 pmr open");
    irqc(1, "R3 reopened");

    ack(32'd40, 1, "R4 ack id");
    irqc(0, "R4 irq drops after ack");
    rd(3'd5, 32'h80, "R4 running prio");

    cand(1, 14'd41, 8'h80);
    irqc(0, "R6 equal prio no preempt");
    cand(1, 14'd41, 8'h7F);
    irqc(1, "R6 more urgent preempts");
    ack(32'd41, 1, "R6 nested ack");
    rd(3'd5, 32'h7F, "R6 running nested");

    wr(3'd4, 32'd40, 0, "R8 eoi not top");
    rd(3'd5, 32'h7F, "R8 unchanged");
    wr(3'd4, 32'd41, 1, "R9 mode0 eoi deactivates");
    rd(3'd5, 32'h80, "R7 pop to previous");

    wr(3'd0, 32'h2, 0, "R9 mode1");
    wr(3'd4, 32'd40, 0, "R9 mode1 eoi no deact");
    rd(3'd5, 32'hFF, "R7 pop to idle");
    wr(3'd6, 32'd40, 1, "R9 deactivate write");
    wr(3'd0, 0, 0, "R9 mode0");
    wr(3'd6, 32'd40, 0, "R9 deactivate ignored mode0");
    wr(3'd4, 32'd0, 0, "R8 eoi empty stack");
    rd(3'd5, 32'hFF, "R8 still idle");

    cand(1, 14'd1020, 8'h10);
    irqc(0, "R11 reserved low edge");
    ack(32'd1023, 0, "R11 reserved ack spurious");
    cand(1, 14'd8191, 8'h10);
    irqc(0, "R11 reserved high edge");
    cand(1, 14'd8192, 8'h10);
    irqc(1, "R11 8192 valid");
    cand(1, 14'd1019, 8'h10);
    irqc(1, "R11 1019 valid");

    for (int k = 0; k < 4; k++) begin
      cand(1, 14'(50 + k), 8'(8'h40 - 8'(k * 16)));
      ack(32'(50 + k), 1, "R10 fill stack");
    end
    rd(3'd5, 32'h10, "R10 running at depth 4");
    cand(1, 14'd60, 8'h05);
    irqc(0, "R10 full blocks irq");
    ack(32'd1023, 0, "R10 full ack spurious");
    wr(3'd4, 32'd53, 1, "R7 pop from full");
    rd(3'd5, 32'h20, "R7 running after pop");
    irqc(1, "R10 slot free again");
    cand(0, 14'd60, 8'h05);
    irqc(0, "R3 candidate not valid");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule